// File: doc/BRIEF.md
# Cache Tag Directory with Hit Compare and Burst-Ready Logic

This block holds, for every cache line index, a tag word and three status bits (valid, dirty, write-through). When an index is applied, it reads the stored tag and status without waiting for a clock. It compares the stored tag with the tag presented on the input and raises a hit flag when the two are equal and the entry's valid bit is set. Tag writes and status writes happen on the rising clock edge and each has its own enable. An active-low clocked clear wipes the status of every entry in one cycle, so all lines become invalid at once.

A mode input selects how the status bits behave. In dedicated mode the block maintains them itself: a tag fill marks the line valid and clean, and a write hit to a copy-back line marks it dirty. In generic mode the three bits are plain storage owned by the user. The block also produces an active-low burst-ready strobe from the hit result, the write-through bit, the bus direction and an external ready input. Two chip selects and a power-down input gate the whole block, which allows several blocks to be stacked for a deeper directory.

Top module: `tcd_tag_dir`

## Requirements
- R1: On a rising edge with the block active and `tag_we` high, the tag at `addr` takes `tag_in`; `tag_q` shows the stored tag at `addr` combinationally while active and `tag_oe` is high, and reads zero otherwise.
- R2: `hit` is high exactly when the block is active, the stored tag at `addr` equals `tag_in`, and status bit 0 (valid) of that entry is set, in either mode.
- R3: `stat_q` shows the entry's status with bit 0 = valid, bit 1 = dirty, bit 2 = write-through, combinationally while active and `stat_oe` is high, and reads zero otherwise.
- R4: The two write enables are independent: `stat_we` alone never changes a stored tag.
- R5: When `rst_n` is low at a rising edge, every entry's status becomes 000 in that single cycle; stored tags keep their values, and any tag or status write in the same cycle is dropped.
- R6: In dedicated mode (`generic_md` low), a tag write sets the entry's status to valid = 1, dirty = 0, write-through = `stat_in[2]`.
- R7: In dedicated mode, a cycle with `hit` and `rw_wr` high and no tag or status write sets dirty when the entry's write-through bit is 0, and leaves the status unchanged when it is 1.
- R8: In generic mode, `stat_we` stores `stat_in` unchanged, a tag write leaves the status untouched, and a write hit does not set dirty.
- R9: In dedicated mode, `stat_we` without `tag_we` stores `stat_in` unchanged; a tag write takes precedence over it.
- R10: `rdy_n` is low when the block is active, `rdy_oe` is high, `rdy_force_hi` is low, and either `rdy_ext_n` is low, or `hit` is high with `rw_wr` low (read hit), or `hit` is high with `rw_wr` high and write-through clear; otherwise it is high.
- R11: `rdy_force_hi` high, or `rdy_oe` low, holds `rdy_n` high regardless of hit and the external ready input.
- R12: The block is active only while `cs_a_n` is low, `cs_b` is high and `pwr_dn` is low; while inactive, writes and automatic status updates are ignored, `hit` is low, `tag_q` and `stat_q` read zero and `rdy_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clears act on its rising edge |
| rst_n | input | 1 | Active-low clocked clear of all status bits |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| pwr_dn | input | 1 | Standby request; block inactive while high |
| generic_md | input | 1 | 0 = dedicated status handling, 1 = user-owned status bits |
| addr | input | AW | Entry index |
| tag_in | input | TW | Tag to compare and to write |
| stat_in | input | 3 | Status to write (bit 0 valid, bit 1 dirty, bit 2 write-through) |
| tag_we | input | 1 | Tag write enable |
| stat_we | input | 1 | Status write enable |
| rw_wr | input | 1 | Bus direction: 1 = processor write, 0 = read |
| tag_oe | input | 1 | Enables the tag read port |
| stat_oe | input | 1 | Enables the status read port |
| rdy_oe | input | 1 | Enables the burst-ready output |
| rdy_ext_n | input | 1 | External burst-ready request, active low |
| rdy_force_hi | input | 1 | Forces burst-ready inactive |
| tag_q | output | TW | Stored tag at `addr`, or zero when disabled |
| stat_q | output | 3 | Stored status at `addr`, or zero when disabled |
| hit | output | 1 | Tag equal and entry valid |
| rdy_n | output | 1 | Burst ready, active low |

## Verification
The bench keeps its own copy of the directory and goes after the cases where status handling can go wrong. A write hit to a write-through line must not become dirty and must not raise burst-ready; a design that ignored write-through would mark it dirty and acknowledge it. A write hit in generic mode must leave the status alone, and a design that kept dedicated updates active there would set dirty on it. A clear that coincides with a tag write must drop the write and keep the old tag, and a design that let the write through would report a different tag afterwards. Writes presented while deselected or powered down must leave no trace, and a valid bit cleared through the status port must stop a matching tag from hitting.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
   // Status word layout; bit positions are decoded by the read port users.
   typedef struct packed {
      logic wt;    // bit 2: write-through
      logic dty;   // bit 1: dirty
      logic vld;   // bit 0: valid
   } tcd_stat_t;

   localparam int unsigned STAT_W = 3;
   localparam tcd_stat_t STAT_CLR = '{wt: 1'b0, dty: 1'b0, vld: 1'b0};
endpackage

// File: rtl/tcd_tag_store.sv
module tcd_tag_store #(
   parameter int unsigned AW = 8,
   parameter int unsigned TW = 12
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [TW-1:0] wr_data,
   output logic [TW-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [TW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= wr_data;
      end
   end

   assign rd_data = mem[addr];
endmodule

// File: rtl/tcd_stat_store.sv
module tcd_stat_store
   import tcd_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          active,
   input  logic          generic_md,
   input  logic          tag_we,
   input  logic          stat_we,
   input  logic          wr_hit,
   input  logic [AW-1:0] addr,
   input  tcd_stat_t     stat_in,
   output tcd_stat_t     rd_stat
);
   localparam int unsigned DEPTH = 1 << AW;

   tcd_stat_t st [DEPTH];

   // Next value for the addressed entry, shared by all entries.
   tcd_stat_t upd_val;
   logic      upd_en;
   tcd_stat_t cur;

   assign cur = st[addr];

   always_comb begin
      upd_val = cur;
      upd_en  = 1'b0;
      if (active) begin
         if (!generic_md) begin
            if (tag_we) begin
               upd_en  = 1'b1;
               upd_val = '{wt: stat_in.wt, dty: 1'b0, vld: 1'b1};
            end else if (stat_we) begin
               upd_en  = 1'b1;
               upd_val = stat_in;
            end else if (wr_hit && !cur.wt) begin
               upd_en      = 1'b1;
               upd_val.dty = 1'b1;
            end
         end else if (stat_we) begin
            upd_en  = 1'b1;
            upd_val = stat_in;
         end
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic sel;
      assign sel = (addr == AW'(gi));
      always_ff @(posedge clk) begin
         if (!clr_n) begin
            st[gi] <= STAT_CLR;
         end else if (upd_en && sel) begin
            st[gi] <= upd_val;
         end
      end
   end

   assign rd_stat = cur;
endmodule

// File: rtl/tcd_hit_rdy.sv
module tcd_hit_rdy
   import tcd_pkg::*;
#(
   parameter int unsigned TW = 12
) (
   input  logic          active,
   input  logic [TW-1:0] tag_in,
   input  logic [TW-1:0] rd_tag,
   input  tcd_stat_t     rd_stat,
   input  logic          rw_wr,
   input  logic          rdy_oe,
   input  logic          rdy_ext_n,
   input  logic          rdy_force_hi,
   output logic          hit,
   output logic          rdy_n
);
   logic tag_eq;
   logic int_rdy;

   assign tag_eq  = (rd_tag == tag_in);
   assign hit     = active && tag_eq && rd_stat.vld;
   assign int_rdy = hit && (!rw_wr || !rd_stat.wt);

   always_comb begin
      rdy_n = 1'b1;
      if (active && rdy_oe && !rdy_force_hi) begin
         rdy_n = !(int_rdy || !rdy_ext_n);
      end
   end
endmodule

// File: rtl/tcd_tag_dir.sv
module tcd_tag_dir
   import tcd_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_a_n,
   input  logic          cs_b,
   input  logic          pwr_dn,
   input  logic          generic_md,
   input  logic [AW-1:0] addr,
   input  logic [TW-1:0] tag_in,
   input  logic [2:0]    stat_in,
   input  logic          tag_we,
   input  logic          stat_we,
   input  logic          rw_wr,
   input  logic          tag_oe,
   input  logic          stat_oe,
   input  logic          rdy_oe,
   input  logic          rdy_ext_n,
   input  logic          rdy_force_hi,
   output logic [TW-1:0] tag_q,
   output logic [2:0]    stat_q,
   output logic          hit,
   output logic          rdy_n
);
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("tcd_tag_dir: AW must be within 1..16");
   end
   if (TW < 1 || TW > 64) begin : g_bad_tw
      $error("tcd_tag_dir: TW must be within 1..64");
   end

   logic          active;
   logic [TW-1:0] rd_tag;
   tcd_stat_t     rd_stat;
   logic          wr_hit;

   assign active = !cs_a_n && cs_b && !pwr_dn;
   assign wr_hit = hit && rw_wr;

   tcd_tag_store #(.AW(AW), .TW(TW)) u_tags (
      .clk     (clk),
      .wr_en   (active && rst_n && tag_we),
      .addr    (addr),
      .wr_data (tag_in),
      .rd_data (rd_tag)
   );

   tcd_stat_store #(.AW(AW)) u_stat (
      .clk        (clk),
      .clr_n      (rst_n),
      .active     (active),
      .generic_md (generic_md),
      .tag_we     (tag_we),
      .stat_we    (stat_we),
      .wr_hit     (wr_hit),
      .addr       (addr),
      .stat_in    (tcd_stat_t'(stat_in)),
      .rd_stat    (rd_stat)
   );

   tcd_hit_rdy #(.TW(TW)) u_cmp (
      .active       (active),
      .tag_in       (tag_in),
      .rd_tag       (rd_tag),
      .rd_stat      (rd_stat),
      .rw_wr        (rw_wr),
      .rdy_oe       (rdy_oe),
      .rdy_ext_n    (rdy_ext_n),
      .rdy_force_hi (rdy_force_hi),
      .hit          (hit),
      .rdy_n        (rdy_n)
   );

   assign tag_q  = (active && tag_oe)  ? rd_tag : '0;
   assign stat_q = (active && stat_oe) ? rd_stat : '0;
endmodule

// File: rtl/tcd_tag_dir_chk.sv
module tcd_tag_dir_chk #(
   parameter int unsigned AW = 8,
   parameter int unsigned TW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          active,
   input logic          generic_md,
   input logic [AW-1:0] addr,
   input logic [TW-1:0] tag_in,
   input logic          tag_we,
   input logic          stat_we,
   input logic          rw_wr,
   input logic          rdy_force_hi,
   input logic          rdy_oe,
   input logic [TW-1:0] rd_tag,
   input logic [2:0]    rd_stat,
   input logic          hit,
   input logic          rdy_n
);
   p_hit_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (active && rd_stat[0] && rd_tag == tag_in));

   p_clear_all_r5: assert property (@(posedge clk)
      !rst_n |=> (rd_stat == 3'b000));

   p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tag_we && !generic_md) ##1 $stable(addr) |-> rd_stat[0]);

   p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !generic_md && hit && rw_wr && !tag_we && !stat_we && !rd_stat[2])
      ##1 $stable(addr) |-> rd_stat[1]);

   p_force_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_force_hi || !rdy_oe) |-> rdy_n);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!hit && rdy_n));

   p_idle_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !active ##1 $stable(addr) |-> ($stable(rd_tag) && $stable(rd_stat)));
endmodule

bind tcd_tag_dir tcd_tag_dir_chk #(.AW(AW), .TW(TW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active       (active),
   .generic_md   (generic_md),
   .addr         (addr),
   .tag_in       (tag_in),
   .tag_we       (tag_we),
   .stat_we      (stat_we),
   .rw_wr        (rw_wr),
   .rdy_force_hi (rdy_force_hi),
   .rdy_oe       (rdy_oe),
   .rd_tag       (rd_tag),
   .rd_stat      (rd_stat),
   .hit          (hit),
   .rdy_n        (rdy_n)
);

// File: tb/tcd_tag_dir_bench.sv
`timescale 1ns/1ps
module tcd_tag_dir_bench;
   localparam int unsigned AW = 4;
   localparam int unsigned TW = 12;
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned NV = 18;

   // Vector: [22] generic, [21] tag_we, [20] stat_we, [19] rw_wr,
   //         [18:15] addr, [14:3] tag, [2:0] status in
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 12'h103, 3'b000},  // read, entry invalid
      {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 12'hABC, 3'b000},  // fill, copy-back
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 12'hABC, 3'b000},  // read hit
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 12'hABD, 3'b000},  // read miss
      {1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 12'hABC, 3'b000},  // write hit -> dirty
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 12'hABC, 3'b000},  // read, dirty shown
      {1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 12'h555, 3'b100},  // fill, write-through
      {1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 12'h555, 3'b000},  // write hit, wt
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 12'h555, 3'b000},  // read hit
      {1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 12'h555, 3'b000},  // status write clears valid
      {1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 12'h555, 3'b000},  // no hit now
      {1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 12'h107, 3'b110},  // generic status write
      {1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 12'h107, 3'b000},  // read, no valid
      {1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 12'h107, 3'b001},  // generic status write
      {1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 12'h107, 3'b000},  // write hit, no dirty
      {1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 12'h107, 3'b000},  // read back status
      {1'b1, 1'b1, 1'b0, 1'b0, 4'd7, 12'h777, 3'b110},  // generic tag write
      {1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 12'h777, 3'b000}   // hit, status unchanged
   };

   logic          clk = 1'b0;
   logic          rst_n, cs_a_n, cs_b, pwr_dn, generic_md;
   logic [AW-1:0] addr;
   logic [TW-1:0] tag_in;
   logic [2:0]    stat_in;
   logic          tag_we, stat_we, rw_wr, tag_oe, stat_oe, rdy_oe;
   logic          rdy_ext_n, rdy_force_hi;
   logic [TW-1:0] tag_q;
   logic [2:0]    stat_q;
   logic          hit, rdy_n;

   logic [TW-1:0] m_tag [DEPTH];
   logic [2:0]    m_st  [DEPTH];

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   tcd_tag_dir #(.AW(AW), .TW(TW)) u_tcd_tag_dir (
      .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .pwr_dn(pwr_dn),
      .generic_md(generic_md), .addr(addr), .tag_in(tag_in), .stat_in(stat_in),
      .tag_we(tag_we), .stat_we(stat_we), .rw_wr(rw_wr), .tag_oe(tag_oe),
      .stat_oe(stat_oe), .rdy_oe(rdy_oe), .rdy_ext_n(rdy_ext_n),
      .rdy_force_hi(rdy_force_hi), .tag_q(tag_q), .stat_q(stat_q), .hit(hit),
      .rdy_n(rdy_n)
   );

   function automatic logic m_active();
      return !cs_a_n && cs_b && !pwr_dn;
   endfunction

   function automatic logic m_hit();
      return m_active() && m_tag[addr] == tag_in && m_st[addr][0];
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_outs(string req);
      logic e_hit, e_rdy;
      e_hit = m_hit();
      e_rdy = 1'b1;
      if (m_active() && rdy_oe && !rdy_force_hi)
         e_rdy = !(!rdy_ext_n || (e_hit && (!rw_wr || !m_st[addr][2])));
      chk(req, "tag_q",  32'(tag_q),  (m_active() && tag_oe)  ? 32'(m_tag[addr]) : 32'h0);
      chk(req, "stat_q", 32'(stat_q), (m_active() && stat_oe) ? 32'(m_st[addr])  : 32'h0);
      chk(req, "hit",    32'(hit),    32'(e_hit));
      chk(req, "rdy_n",  32'(rdy_n),  32'(e_rdy));
   endtask

   task automatic update_model();
      logic h;
      h = m_hit();
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_st[i] = 3'b000;
      end else if (m_active()) begin
         if (tag_we) m_tag[addr] = tag_in;
         if (!generic_md) begin
            if (tag_we)                           m_st[addr] = {stat_in[2], 2'b01};
            else if (stat_we)                     m_st[addr] = stat_in;
            else if (h && rw_wr && !m_st[addr][2]) m_st[addr][1] = 1'b1;
         end else if (stat_we) begin
            m_st[addr] = stat_in;
         end
      end
   endtask

   // Check outputs for current inputs, then take one clock.
   task automatic step(string req);
      #1;
      check_outs(req);
      update_model();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      rst_n = 1'b1; cs_a_n = 1'b0; cs_b = 1'b1; pwr_dn = 1'b0; generic_md = 1'b0;
      addr = '0; tag_in = '0; stat_in = '0; tag_we = 1'b0; stat_we = 1'b0;
      rw_wr = 1'b0; tag_oe = 1'b1; stat_oe = 1'b1; rdy_oe = 1'b1;
      rdy_ext_n = 1'b1; rdy_force_hi = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin m_tag[i] = 'x; m_st[i] = 3'b000; end
      @(negedge clk);
      // Preload every tag in generic mode (status untouched), then clear.
      rst_n = 1'b1; generic_md = 1'b1; tag_we = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         addr = AW'(i); tag_in = TW'(12'h100 + i);
         update_model();
         @(posedge clk); @(negedge clk);
      end
      idle_inputs();
      rst_n = 1'b0;
      step("R5");
      rst_n = 1'b1;
      // Reset state: entry 0 tag kept, status clear, no hit. (R5)
      addr = 4'd0; tag_in = 12'h100;
      step("R5");

      // Vector table walk (R1 R2 R3 R6 R7 R8 R9 R10)
      for (int v = 0; v < NV; v++) begin
         idle_inputs();
         generic_md = VEC[v][22]; tag_we = VEC[v][21]; stat_we = VEC[v][20];
         rw_wr = VEC[v][19]; addr = VEC[v][18:15]; tag_in = VEC[v][14:3];
         stat_in = VEC[v][2:0];
         step("R1/R2/R3/R6/R7/R8/R9/R10");
      end

      // R4: status write alone leaves tag alone.
      idle_inputs(); addr = 4'd3; stat_we = 1'b1; stat_in = 3'b001; tag_in = 12'h000;
      step("R4");
      idle_inputs(); addr = 4'd3; tag_in = 12'h000;
      step("R4");
      chk("R4", "tag kept", 32'(tag_q), 32'h0ABC);

      // R9: tag write wins over status write in dedicated mode.
      idle_inputs(); addr = 4'd9; tag_we = 1'b1; stat_we = 1'b1; stat_in = 3'b010; tag_in = 12'h999;
      step("R9");
      idle_inputs(); addr = 4'd9; tag_in = 12'h999;
      step("R9");
      chk("R9", "status after fill", 32'(stat_q), 32'h1);

      // R10: external ready on a miss.
      idle_inputs(); addr = 4'd2; tag_in = 12'hFFF; rdy_ext_n = 1'b0;
      step("R10");
      chk("R10", "ext ready", 32'(rdy_n), 32'h0);

      // R11: forced high and output disabled on a read hit.
      idle_inputs(); addr = 4'd3; tag_in = 12'hABC; rdy_force_hi = 1'b1; rdy_ext_n = 1'b0;
      step("R11");
      idle_inputs(); addr = 4'd3; tag_in = 12'hABC; rdy_oe = 1'b0;
      step("R11");
      // R1/R3: output enables off.
      idle_inputs(); addr = 4'd3; tag_in = 12'hABC; tag_oe = 1'b0; stat_oe = 1'b0;
      step("R1/R3");

      // R12: deselected and powered-down writes ignored.
      idle_inputs(); cs_a_n = 1'b1; addr = 4'd3; tag_in = 12'hEEE; tag_we = 1'b1; stat_we = 1'b1;
      step("R12");
      idle_inputs(); cs_b = 1'b0; addr = 4'd3; tag_in = 12'hABC; rw_wr = 1'b1; rdy_ext_n = 1'b0;
      step("R12");
      idle_inputs(); pwr_dn = 1'b1; addr = 4'd3; tag_in = 12'hDDD; tag_we = 1'b1;
      step("R12");
      idle_inputs(); addr = 4'd3; tag_in = 12'hABC;
      step("R12");
      chk("R12", "tag after idle writes", 32'(tag_q), 32'h0ABC);
      chk("R12", "hit after idle writes", 32'(hit), 32'h1);

      // R5: clear with a concurrent tag write.
      idle_inputs(); rst_n = 1'b0; addr = 4'd3; tag_in = 12'h111; tag_we = 1'b1;
      step("R5");
      idle_inputs(); addr = 4'd3; tag_in = 12'hABC;
      step("R5");
      chk("R5", "tag kept over clear", 32'(tag_q), 32'h0ABC);
      chk("R5", "status cleared", 32'(stat_q), 32'h0);
      idle_inputs(); addr = 4'd7; tag_in = 12'h777;
      step("R5");
      chk("R5", "other entry cleared", 32'(stat_q), 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule